// File: doc/BRIEF.md
# Paged Address Translator with Key/Lock Protection

This block turns a 16-bit logical word address into a 20-bit physical word address. A 4-bit address-state value picks one of 16 groups of page entries. The top four bits of the logical address pick one of 16 entries in that group. The entry supplies an 8-bit physical page number, which selects one of 256 pages of 4K words. The low 12 address bits pass through unchanged as the offset inside the page.

Each entry also holds a 4-bit lock and a write-protect bit. The processor's 4-bit access key is compared with the lock on every request. An active-low protect error reports a key/lock mismatch or a write to a protected page. Key value zero marks the privileged state: it opens every lock, and the block reports it on a privilege output. Software loads entries through a synchronous write port. The translated address and the error appear together, one clock after the request.

Top module: `page_mmu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `out_valid`=0, `ext_page`=0, `page_off`=0, `prot_err_n`=1 and `priv_state`=0.
- R2: After reset, the entry at group g and index i holds page number g*16+i, lock 0 and write-protect 0.
- R3: A request is sampled at a clock edge with `req_valid`=1. On the following cycle `out_valid`=1 and `ext_page` holds the page number of the entry at group `addr_state` and index `log_addr[15:12]`.
- R4: On that same cycle `page_off` equals the request's `log_addr[11:0]`.
- R5: The access key is compared with the entry's lock. If the key is non-zero and differs from the lock, `prot_err_n` is 0 in the same cycle as the translated address.
- R6: Key 0 never causes a lock-mismatch error. `priv_state` is 1 in the result cycle exactly when the request's key was 0.
- R7: A write request (`req_write`=1) to an entry with write-protect 1 drives `prot_err_n` to 0 for any key. A read of that entry raises no write-protect error.
- R8: A load (`ld_en`=1) writes `ld_ppn`, `ld_lock` and `ld_wp` to the entry at (`ld_group`, `ld_index`). A request in the same cycle as the load sees the old contents. Later requests see the new contents.
- R9: A cycle after an edge with `req_valid`=0 has `out_valid`=0 and `prot_err_n`=1.
- R10: A load changes only the addressed entry. Neighbouring entries keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Memory request strobe |
| req_write | input | 1 | 1 = write access, 0 = read |
| addr_state | input | 4 | Page-group select |
| access_key | input | 4 | Key from status word; 0 = privileged |
| log_addr | input | 16 | Logical word address |
| ld_en | input | 1 | Page-entry load strobe |
| ld_group | input | 4 | Group of entry being loaded |
| ld_index | input | 4 | Index of entry being loaded |
| ld_ppn | input | 8 | Page number to load |
| ld_lock | input | 4 | Lock value to load |
| ld_wp | input | 1 | Write-protect bit to load |
| out_valid | output | 1 | Result valid |
| ext_page | output | 8 | Translated physical page number |
| page_off | output | 12 | In-page word offset |
| prot_err_n | output | 1 | Active-low protection error |
| priv_state | output | 1 | Request was made with the privileged key |

## Verification
The hardest case is a load and a request aimed at the same entry on the same clock edge. The bench drives both strobes in one cycle. It expects the pre-load page number in the result and the new value on the next request. A second hard case is telling a write-protect fault apart from a key fault. For this the bench loads a protected entry with lock 0 and writes to it using the master key. Any error seen there can only come from the write-protect path. The bench also checks that a nearby entry was left alone by the load. It then resets in mid-run and checks that the loaded entries are back at their defaults.

// File: rtl/page_mmu_pkg.sv
// Shared geometry and page-entry layout for the paged translator.
package page_mmu_pkg;
    localparam int GRP_W = 4;   // address-state width
    localparam int IDX_W = 4;   // page index width inside a group
    localparam int PPN_W = 8;   // physical page number width
    localparam int OFF_W = 12;  // in-page offset width
    localparam int KEY_W = 4;   // access key / lock width

    // One page entry: physical page, access lock, write-protect bit.
    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [KEY_W-1:0] lock;
        logic             wp;
    } pte_t;
endpackage

// File: rtl/page_mmu_table.sv
// Page-entry storage: 2^(GRP_W+IDX_W) entries in flops.
// Assumes one synchronous write port and one combinational read port.
// A read in the same cycle as a write to the same entry returns old data.
// Reset loads each entry with page = flat index, lock 0, writes enabled.
module page_mmu_table
    import page_mmu_pkg::*;
#(
    parameter int GW = GRP_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [GW-1:0] wr_grp,
    input  logic [IW-1:0] wr_idx,
    input  pte_t          wr_data,
    input  logic [GW-1:0] rd_grp,
    input  logic [IW-1:0] rd_idx,
    output pte_t          rd_data
);
    localparam int SEL_W   = GW + IW;
    localparam int ENTRIES = 1 << SEL_W;

    pte_t             mem [ENTRIES];
    logic [SEL_W-1:0] wr_sel;
    logic [SEL_W-1:0] rd_sel;

    // Flatten group/index pairs into table addresses.
    always_comb begin
        wr_sel = {wr_grp, wr_idx};
        rd_sel = {rd_grp, rd_idx};
    end

    // Entry storage with identity-map reset and synchronous load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < ENTRIES; k++) begin
                mem[k].ppn  <= PPN_W'(k);
                mem[k].lock <= '0;
                mem[k].wp   <= 1'b0;
            end
        end else if (wr_en) begin
            mem[wr_sel] <= wr_data;
        end
    end

    // Combinational lookup of the selected entry.
    always_comb begin
        rd_data = mem[rd_sel];
    end
endmodule

// File: rtl/page_mmu_prot.sv
// Protection decision for one access. Purely combinational.
// A non-zero key must equal the lock. Key zero is the master key and
// the privileged state. Writes to protected pages always fault.
module page_mmu_prot
    import page_mmu_pkg::*;
#(
    parameter int KW = KEY_W
) (
    input  logic          req,
    input  logic          is_write,
    input  logic [KW-1:0] key,
    input  logic [KW-1:0] lock,
    input  logic          wp,
    output logic          priv,
    output logic          fault
);
    logic key_fault;
    logic wp_fault;

    // Derive privilege and the two independent fault sources.
    always_comb begin
        priv      = (key == '0);
        key_fault = req && !priv && (key != lock);
        wp_fault  = req && is_write && wp;
        fault     = key_fault || wp_fault;
    end
endmodule

// File: rtl/page_mmu.sv
// Top of the paged translator. Logical address = {index, offset}.
// The page number and protect error are registered together one cycle
// after the request. Synchronous active-low reset.
module page_mmu
    import page_mmu_pkg::*;
#(
    parameter int GW = GRP_W,
    parameter int IW = IDX_W,
    parameter int PW = PPN_W,
    parameter int OW = OFF_W,
    parameter int KW = KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [GW-1:0]    addr_state,
    input  logic [KW-1:0]    access_key,
    input  logic [IW+OW-1:0] log_addr,
    input  logic             ld_en,
    input  logic [GW-1:0]    ld_group,
    input  logic [IW-1:0]    ld_index,
    input  logic [PW-1:0]    ld_ppn,
    input  logic [KW-1:0]    ld_lock,
    input  logic             ld_wp,
    output logic             out_valid,
    output logic [PW-1:0]    ext_page,
    output logic [OW-1:0]    page_off,
    output logic             prot_err_n,
    output logic             priv_state
);
    localparam int LA_W = IW + OW;

    pte_t          ld_entry;
    pte_t          sel_entry;
    logic [IW-1:0] req_idx;
    logic          fault;
    logic          priv;

    // Pack the load fields and split the logical address.
    always_comb begin
        ld_entry.ppn  = ld_ppn;
        ld_entry.lock = ld_lock;
        ld_entry.wp   = ld_wp;
        req_idx       = log_addr[LA_W-1:OW];
    end

    page_mmu_table #(.GW(GW), .IW(IW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ld_en),
        .wr_grp  (ld_group),
        .wr_idx  (ld_index),
        .wr_data (ld_entry),
        .rd_grp  (addr_state),
        .rd_idx  (req_idx),
        .rd_data (sel_entry)
    );

    page_mmu_prot #(.KW(KW)) u_prot (
        .req      (req_valid),
        .is_write (req_write),
        .key      (access_key),
        .lock     (sel_entry.lock),
        .wp       (sel_entry.wp),
        .priv     (priv),
        .fault    (fault)
    );

    // Register translation and protection result together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            ext_page   <= '0;
            page_off   <= '0;
            prot_err_n <= 1'b1;
            priv_state <= 1'b0;
        end else if (req_valid) begin
            out_valid  <= 1'b1;
            ext_page   <= sel_entry.ppn;
            page_off   <= log_addr[OW-1:0];
            prot_err_n <= !fault;
            priv_state <= priv;
        end else begin
            out_valid  <= 1'b0;
            prot_err_n <= 1'b1;
            priv_state <= 1'b0;
        end
    end
endmodule

// File: rtl/page_mmu_chk.sv
// Port-level property checker for page_mmu, attached by bind.
module page_mmu_chk #(
    parameter int GW = 4,
    parameter int IW = 4,
    parameter int PW = 8,
    parameter int OW = 12,
    parameter int KW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [KW-1:0]    access_key,
    input logic [IW+OW-1:0] log_addr,
    input logic             out_valid,
    input logic [OW-1:0]    page_off,
    input logic             prot_err_n,
    input logic             priv_state
);
    // R9: idle cycle gives no valid result and no error.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!out_valid && prot_err_n));

    // R3: each request yields a valid result next cycle.
    p_result_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    // R4: offset passes through unchanged.
    p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (page_off == $past(log_addr[OW-1:0])));

    // R6: a read with the master key never faults.
    p_master_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && access_key == '0) |=> prot_err_n);

    // R6: privilege flag follows the request's key.
    p_priv_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (priv_state == ($past(access_key) == '0)));

    // R5: an error is only reported alongside a valid result.
    p_err_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_err_n |-> out_valid);
endmodule

bind page_mmu page_mmu_chk #(.GW(GW), .IW(IW), .PW(PW), .OW(OW), .KW(KW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .access_key (access_key),
    .log_addr   (log_addr),
    .out_valid  (out_valid),
    .page_off   (page_off),
    .prot_err_n (prot_err_n),
    .priv_state (priv_state)
);

// File: tb/page_mmu_tb.sv
module page_mmu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  addr_state = '0, access_key = '0;
    logic [15:0] log_addr = '0;
    logic        ld_en = 1'b0;
    logic [3:0]  ld_group = '0, ld_index = '0, ld_lock = '0;
    logic [7:0]  ld_ppn = '0;
    logic        ld_wp = 1'b0;
    logic        out_valid, prot_err_n, priv_state;
    logic [7:0]  ext_page;
    logic [11:0] page_off;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    page_mmu u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .addr_state(addr_state), .access_key(access_key), .log_addr(log_addr),
        .ld_en(ld_en), .ld_group(ld_group), .ld_index(ld_index), .ld_ppn(ld_ppn),
        .ld_lock(ld_lock), .ld_wp(ld_wp), .out_valid(out_valid), .ext_page(ext_page),
        .page_off(page_off), .prot_err_n(prot_err_n), .priv_state(priv_state)
    );

    // {write, group, key, address, expected page, expected prot_err_n}
    localparam logic [33:0] VEC [8] = '{
        {1'b0, 4'h0, 4'h0, 16'h0123, 8'h00, 1'b1},
        {1'b0, 4'h3, 4'h0, 16'h5ABC, 8'h35, 1'b1},
        {1'b0, 4'hF, 4'h0, 16'hFFFF, 8'hFF, 1'b1},
        {1'b0, 4'h9, 4'h5, 16'h2001, 8'h92, 1'b0},
        {1'b1, 4'h6, 4'h0, 16'hA555, 8'h6A, 1'b1},
        {1'b1, 4'hC, 4'h7, 16'h3000, 8'hC3, 1'b0},
        {1'b0, 4'h0, 4'h0, 16'hF0F0, 8'h0F, 1'b1},
        {1'b1, 4'h5, 4'h0, 16'h0FFF, 8'h50, 1'b1}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive a request for one edge, then check the result at the next negedge.
    task automatic do_req(input logic w, input logic [3:0] g, input logic [3:0] k,
                          input logic [15:0] a, input logic [7:0] exp_pg,
                          input logic exp_en, input string req);
        req_valid = 1'b1; req_write = w; addr_state = g; access_key = k; log_addr = a;
        @(negedge clk);
        req_valid = 1'b0; ld_en = 1'b0;
        check(req, "out_valid", int'(out_valid), 1);
        check(req, "ext_page", int'(ext_page), int'(exp_pg));
        check(req, "page_off", int'(page_off), int'(a[11:0]));
        check(req, "prot_err_n", int'(prot_err_n), int'(exp_en));
        check(req, "priv_state", int'(priv_state), int'(k == 4'h0));
    endtask

    task automatic do_load(input logic [3:0] g, input logic [3:0] i, input logic [7:0] p,
                           input logic [3:0] l, input logic wp);
        ld_en = 1'b1; ld_group = g; ld_index = i; ld_ppn = p; ld_lock = l; ld_wp = wp;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1: reset values
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "ext_page", int'(ext_page), 0);
        check("R1", "page_off", int'(page_off), 0);
        check("R1", "prot_err_n", int'(prot_err_n), 1);
        check("R1", "priv_state", int'(priv_state), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R5 R6 R7: table walk over the default map
        for (int v = 0; v < 8; v++) begin
            do_req(VEC[v][33], VEC[v][32:29], VEC[v][28:25], VEC[v][24:9],
                   VEC[v][8:1], VEC[v][0], "R2/R3/R5");
        end

        // R9: idle cycle
        @(negedge clk);
        check("R9", "out_valid", int'(out_valid), 0);
        check("R9", "prot_err_n", int'(prot_err_n), 1);

        // R8 R5: load a locked entry and probe it with several keys
        do_load(4'h2, 4'h7, 8'hA5, 4'h6, 1'b0);
        do_req(1'b0, 4'h2, 4'h6, 16'h7123, 8'hA5, 1'b1, "R8");
        do_req(1'b0, 4'h2, 4'h3, 16'h7123, 8'hA5, 1'b0, "R5");
        do_req(1'b1, 4'h2, 4'h0, 16'h7456, 8'hA5, 1'b1, "R6");
        // R10: neighbour untouched
        do_req(1'b0, 4'h2, 4'h0, 16'h6000, 8'h26, 1'b1, "R10");

        // R7: write-protected page, lock 0, master key
        do_load(4'h4, 4'h1, 8'h3C, 4'h0, 1'b1);
        do_req(1'b1, 4'h4, 4'h0, 16'h1010, 8'h3C, 1'b0, "R7");
        do_req(1'b0, 4'h4, 4'h0, 16'h1010, 8'h3C, 1'b1, "R7");

        // R8: load and request to the same entry in one cycle
        ld_en = 1'b1; ld_group = 4'h1; ld_index = 4'h1; ld_ppn = 8'h77;
        ld_lock = 4'h0; ld_wp = 1'b0;
        do_req(1'b0, 4'h1, 4'h0, 16'h1000, 8'h11, 1'b1, "R8");
        do_req(1'b0, 4'h1, 4'h0, 16'h1000, 8'h77, 1'b1, "R8");

        // R1 R2: reset mid-run restores the default map
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "ext_page", int'(ext_page), 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(1'b0, 4'h2, 4'h3, 16'h7123, 8'h27, 1'b0, "R2");
        do_req(1'b1, 4'h4, 4'h0, 16'h1010, 8'h41, 1'b1, "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule